// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets up to four processor cores interrupt one another. Each core owns a command slot made of a valid strobe, a two-bit operation code and a core-index argument. Through its slot a core can do four things: raise an interrupt on another core, ask whether a given core already has an interrupt waiting, ask which cores are waiting on it, and acknowledge one of those senders. Each core receives a single level-sensitive interrupt line and has a readback register that it reads after a query.

Pending state is held as one bit for every ordered sender/receiver pair. A receiver's line is the OR of its column, so requests from several senders merge into one asserted line. The receiver finds out who called by reading a sender mask, and then clears each sender by its index. A core never raises an interrupt on itself through this unit; that case is handled by a local soft interrupt in the core.

Top module: `icis_top`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every interrupt line and every readback register reads zero and no pair is pending.
- R2: Operation code 2'b00 (raise) from core s with argument r, where r differs from s, sets pair (s,r), and interrupt line r is high from the next clock edge.
- R3: A raise whose argument equals the issuing core's own index changes no pending state. The issuer's line stays low and a sender-mask query returns zero.
- R4: Operation code 2'b01 (peek) with argument t loads the issuer's readback with bit 0 equal to the state of line t in the command's cycle and all other bits zero. The value is visible after the next clock edge.
- R5: Operation code 2'b10 (sender query) loads the issuer's readback with a mask where bit i is set when core i has a request pending at the issuer. A lone sender 0, 1, 2 or 3 reads as 1, 2, 4 or 8.
- R6: Requests from several senders to one receiver assert only that receiver's single line, and the sender mask then has one bit per sender.
- R7: Operation code 2'b11 (acknowledge) with argument s clears only pair (s, issuer). Other senders' bits at the issuer stay set.
- R8: A receiver's line stays high for as long as any sender's bit for it is set. It drops on the edge that clears the last bit.
- R9: When a raise and an acknowledge target the same pair in the same cycle, the pair stays set.
- R10: A readback register holds its value in any cycle where its core issues no peek or sender query.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | NCORE | One command strobe per core |
| cmd_op_i | input | 2*NCORE | Operation code per core, core c in bits [2c+1:2c] |
| cmd_arg_i | input | IW*NCORE | Core-index argument per core, core c in bits [IW*c +: IW] |
| rdback_o | output | NCORE*NCORE | Readback register per core, core c in bits [NCORE*c +: NCORE] |
| irq_o | output | NCORE | Level interrupt line per core |

## Verification
The bound checker evaluates the following on every cycle:
- a raise to another core asserts the target's line on the next edge, even against a simultaneous acknowledge of the same pair;
- a self-raise on an idle core leaves its line low;
- a line stays high unless its own core acknowledges;
- peek and sender-query results agree with the line states of the previous cycle;
- readback holds when no query is made.

Which sender bits an acknowledge clears, the exact multi-hot mask after concurrent raises, and the moment the last acknowledge drops a line are hidden state that the ports show only through query sequences. Those are covered by the bench's directed scenarios and its per-cycle reference model under random commands.

// File: rtl/icis_pkg.sv
package icis_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'b00,
        OP_PEEK  = 2'b01,
        OP_WHO   = 2'b10,
        OP_ACK   = 2'b11
    } icis_op_e;

    typedef struct packed {
        logic raise;
        logic peek;
        logic who;
        logic ack;
    } icis_dec_t;

    function automatic icis_dec_t icis_decode(input logic valid, input logic [1:0] op);
        icis_dec_t d;
        d.raise = valid && (op == OP_RAISE);
        d.peek  = valid && (op == OP_PEEK);
        d.who   = valid && (op == OP_WHO);
        d.ack   = valid && (op == OP_ACK);
        return d;
    endfunction

endpackage

// File: rtl/icis_cmd_decode.sv
module icis_cmd_decode
    import icis_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IW    = 2,
    parameter int CORE  = 0
) (
    input  logic             valid,
    input  logic [1:0]       op,
    input  logic [IW-1:0]    arg,
    output logic [NCORE-1:0] raise_tgt,
    output logic [NCORE-1:0] ack_src,
    output logic             peek,
    output logic             who
);
    icis_dec_t dec;

    assign dec  = icis_decode(valid, op);
    assign peek = dec.peek;
    assign who  = dec.who;

    // Self-directed raise and ack are dropped here: the diagonal never sets.
    always_comb begin
        for (int t = 0; t < NCORE; t++) begin
            raise_tgt[t] = dec.raise && (arg == IW'(t)) && (t != CORE);
            ack_src[t]   = dec.ack   && (arg == IW'(t)) && (t != CORE);
        end
    end
endmodule

// File: rtl/icis_pend_matrix.sv
module icis_pend_matrix #(
    parameter int NCORE = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORE*NCORE-1:0]   set_sr,   // [s*NCORE + r]: sender s raises r
    input  logic [NCORE*NCORE-1:0]   ack_rs,   // [r*NCORE + s]: receiver r acks s
    output logic [NCORE*NCORE-1:0]   pend_sr,  // [s*NCORE + r]
    output logic [NCORE-1:0]         irq
);
    logic [NCORE*NCORE-1:0] pend_nx;

    generate
        for (genvar s = 0; s < NCORE; s++) begin : g_snd
            for (genvar r = 0; r < NCORE; r++) begin : g_rcv
                if (s == r) begin : g_diag
                    assign pend_nx[s*NCORE + r] = 1'b0;
                end else begin : g_cell
                    // raise has priority over a same-cycle ack of this pair
                    assign pend_nx[s*NCORE + r] = set_sr[s*NCORE + r] |
                        (pend_sr[s*NCORE + r] & ~ack_rs[r*NCORE + s]);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pend_sr <= '0;
        else     pend_sr <= pend_nx;
    end

    always_comb begin
        for (int r = 0; r < NCORE; r++) begin
            irq[r] = 1'b0;
            for (int s = 0; s < NCORE; s++) irq[r] = irq[r] | pend_sr[s*NCORE + r];
        end
    end
endmodule

// File: rtl/icis_readback.sv
module icis_readback #(
    parameter int NCORE = 4,
    parameter int IW    = 2,
    parameter int CORE  = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCORE*NCORE-1:0] pend_sr,
    input  logic [NCORE-1:0]       irq,
    input  logic                   peek,
    input  logic                   who,
    input  logic [IW-1:0]          arg,
    output logic [NCORE-1:0]       rb
);
    logic [NCORE-1:0] senders;
    logic             tgt_busy;

    always_comb begin
        for (int s = 0; s < NCORE; s++) senders[s] = pend_sr[s*NCORE + CORE];
        tgt_busy = 1'b0;
        for (int t = 0; t < NCORE; t++)
            if (arg == IW'(t)) tgt_busy = irq[t];
    end

    always_ff @(posedge clk) begin
        if (rst)       rb <= '0;
        else if (peek) rb <= NCORE'(tgt_busy);
        else if (who)  rb <= senders;
    end
endmodule

// File: rtl/icis_top.sv
module icis_top
    import icis_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int IW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCORE-1:0]       cmd_valid_i,
    input  logic [2*NCORE-1:0]     cmd_op_i,
    input  logic [IW*NCORE-1:0]    cmd_arg_i,
    output logic [NCORE*NCORE-1:0] rdback_o,
    output logic [NCORE-1:0]       irq_o
);
    logic [NCORE*NCORE-1:0] set_sr;
    logic [NCORE*NCORE-1:0] ack_rs;
    logic [NCORE*NCORE-1:0] pend_sr;
    logic [NCORE-1:0]       peek;
    logic [NCORE-1:0]       who;

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_core
            icis_cmd_decode #(.NCORE(NCORE), .IW(IW), .CORE(c)) u_dec (
                .valid     (cmd_valid_i[c]),
                .op        (cmd_op_i[2*c +: 2]),
                .arg       (cmd_arg_i[IW*c +: IW]),
                .raise_tgt (set_sr[NCORE*c +: NCORE]),
                .ack_src   (ack_rs[NCORE*c +: NCORE]),
                .peek      (peek[c]),
                .who       (who[c])
            );

            icis_readback #(.NCORE(NCORE), .IW(IW), .CORE(c)) u_rb (
                .clk     (clk),
                .rst     (rst),
                .pend_sr (pend_sr),
                .irq     (irq_o),
                .peek    (peek[c]),
                .who     (who[c]),
                .arg     (cmd_arg_i[IW*c +: IW]),
                .rb      (rdback_o[NCORE*c +: NCORE])
            );
        end
    endgenerate

    icis_pend_matrix #(.NCORE(NCORE)) u_mat (
        .clk     (clk),
        .rst     (rst),
        .set_sr  (set_sr),
        .ack_rs  (ack_rs),
        .pend_sr (pend_sr),
        .irq     (irq_o)
    );
endmodule

// File: rtl/icis_checker.sv
module icis_checker #(
    parameter int NCORE = 4,
    parameter int IW    = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCORE-1:0]       cmd_valid_i,
    input logic [2*NCORE-1:0]     cmd_op_i,
    input logic [IW*NCORE-1:0]    cmd_arg_i,
    input logic [NCORE*NCORE-1:0] rdback_o,
    input logic [NCORE-1:0]       irq_o
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_o == '0 && rdback_o == '0));

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_c
            p_self_raise_r3: assert property (@(posedge clk) disable iff (rst)
                (!irq_o[c] && cmd_valid_i == (NCORE'(1) << c) &&
                 cmd_op_i[2*c +: 2] == 2'b00 && cmd_arg_i[IW*c +: IW] == IW'(c))
                |=> !irq_o[c]);

            p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
                (irq_o[c] && !(cmd_valid_i[c] && cmd_op_i[2*c +: 2] == 2'b11))
                |=> irq_o[c]);

            p_peek_r4: assert property (@(posedge clk) disable iff (rst)
                (cmd_valid_i[c] && cmd_op_i[2*c +: 2] == 2'b01)
                |=> (rdback_o[NCORE*c +: NCORE] ==
                     NCORE'($past(irq_o[cmd_arg_i[IW*c +: IW]]))));

            p_who_r5: assert property (@(posedge clk) disable iff (rst)
                (cmd_valid_i[c] && cmd_op_i[2*c +: 2] == 2'b10)
                |=> ((rdback_o[NCORE*c +: NCORE] != '0) == $past(irq_o[c])));

            p_rb_hold_r10: assert property (@(posedge clk) disable iff (rst)
                !(cmd_valid_i[c] && (cmd_op_i[2*c +: 2] == 2'b01 ||
                                     cmd_op_i[2*c +: 2] == 2'b10))
                |=> $stable(rdback_o[NCORE*c +: NCORE]));

            for (genvar r = 0; r < NCORE; r++) begin : g_r
                if (r != c) begin : g_pair
                    p_raise_irq_r2: assert property (@(posedge clk) disable iff (rst)
                        (cmd_valid_i[c] && cmd_op_i[2*c +: 2] == 2'b00 &&
                         cmd_arg_i[IW*c +: IW] == IW'(r))
                        |=> irq_o[r]);

                    p_raise_beats_ack_r9: assert property (@(posedge clk) disable iff (rst)
                        (cmd_valid_i[c] && cmd_op_i[2*c +: 2] == 2'b00 &&
                         cmd_arg_i[IW*c +: IW] == IW'(r) &&
                         cmd_valid_i[r] && cmd_op_i[2*r +: 2] == 2'b11 &&
                         cmd_arg_i[IW*r +: IW] == IW'(c))
                        |=> irq_o[r]);
                end
            end
        end
    endgenerate
endmodule

bind icis_top icis_checker #(.NCORE(NCORE), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_arg_i   (cmd_arg_i),
    .rdback_o    (rdback_o),
    .irq_o       (irq_o)
);

// File: tb/icis_top_tb.sv
`timescale 1ns/1ps
module icis_top_tb;
    localparam int N  = 4;
    localparam int IW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N-1:0]     v   = '0;
    logic [2*N-1:0]   op  = '0;
    logic [IW*N-1:0]  arg = '0;
    logic [N*N-1:0]   rdback;
    logic [N-1:0]     irq;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;

    // reference state: pm[s][r] = sender s pending at receiver r
    bit [N-1:0] pm [N];
    bit [N-1:0] rbm [N];

    icis_top #(.NCORE(N)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid_i(v), .cmd_op_i(op),
        .cmd_arg_i(arg), .rdback_o(rdback), .irq_o(irq)
    );

    always #10 clk = ~clk;

    function automatic bit line_of(int r);
        bit b = 0;
        for (int s = 0; s < N; s++) b |= pm[s][r];
        return b;
    endfunction

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit [N-1:0] npm [N];
        for (int s = 0; s < N; s++) npm[s] = pm[s];
        if (rst) begin
            for (int s = 0; s < N; s++) begin npm[s] = '0; rbm[s] = '0; end
        end else begin
            for (int c = 0; c < N; c++) if (v[c]) begin
                int a = arg[IW*c +: IW];
                case (op[2*c +: 2])
                    2'b01: rbm[c] = {3'b000, line_of(a)};
                    2'b10: begin
                        for (int s = 0; s < N; s++) rbm[c][s] = pm[s][c];
                    end
                    2'b11: if (a != c) npm[a][c] = 1'b0;
                    default: ;
                endcase
            end
            for (int c = 0; c < N; c++)
                if (v[c] && op[2*c +: 2] == 2'b00 && arg[IW*c +: IW] != c)
                    npm[c][arg[IW*c +: IW]] = 1'b1;
        end
        for (int s = 0; s < N; s++) pm[s] = npm[s];
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        v = '0;
        for (int c = 0; c < N; c++) begin
            check($sformatf("R2/R8 model irq core %0d", c), irq[c], line_of(c));
            check($sformatf("R4/R5/R10 model readback core %0d", c),
                  rdback[N*c +: N], rbm[c]);
        end
    endtask

    task automatic cmd(int c, logic [1:0] o, int a);
        v[c] = 1'b1;
        op[2*c +: 2] = o;
        arg[IW*c +: IW] = IW'(a);
    endtask

    function automatic int rbof(int c);
        return rdback[N*c +: N];
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < N; s++) begin pm[s] = '0; rbm[s] = '0; end
        @(negedge clk);
        cmd(0, 2'b00, 1);              // raise during reset must be ignored
        tick(); tick();
        check("R1 reset irq", irq, 0);
        check("R1 reset readback", rdback, 0);
        rst = 1'b0;
        tick();
        check("R1 after reset irq", irq, 0);

        cmd(0, 2'b00, 1); tick();
        check("R2 raise 0->1 line", irq, 4'b0010);

        cmd(2, 2'b01, 1); cmd(3, 2'b01, 0); tick();
        check("R4 peek busy core", rbof(2), 1);
        check("R4 peek idle core", rbof(3), 0);

        cmd(1, 2'b10, 0); tick();
        check("R5 single sender mask", rbof(1), 4'b0001);

        cmd(2, 2'b00, 1); cmd(3, 2'b00, 1); tick();
        check("R6 merged line", irq, 4'b0010);
        cmd(1, 2'b10, 0); tick();
        check("R6 multi-hot mask", rbof(1), 4'b1101);

        cmd(1, 2'b11, 0); tick();
        check("R8 line held after partial ack", irq[1], 1);
        cmd(1, 2'b10, 0); tick();
        check("R7 only sender 0 cleared", rbof(1), 4'b1100);

        cmd(1, 2'b11, 2); tick();
        check("R8 line held with one left", irq[1], 1);
        cmd(1, 2'b11, 3); tick();
        check("R8 line drops on last ack", irq[1], 0);

        cmd(2, 2'b00, 2); tick();
        check("R3 self raise line", irq[2], 0);
        cmd(2, 2'b10, 0); cmd(0, 2'b01, 2); tick();
        check("R3 self raise mask", rbof(2), 0);
        check("R3 self raise peek", rbof(0), 0);

        cmd(0, 2'b00, 3); tick();
        cmd(0, 2'b00, 3); cmd(3, 2'b11, 0); tick();
        check("R9 raise beats ack line", irq[3], 1);
        cmd(3, 2'b10, 0); tick();
        check("R9 raise beats ack mask", rbof(3), 4'b0001);
        cmd(3, 2'b11, 0); tick();
        check("R7 ack clears pair", irq[3], 0);

        cmd(0, 2'b00, 1); cmd(1, 2'b10, 0); tick();
        check("R10 setup readback", rbof(1), 0);
        cmd(1, 2'b00, 2); tick();
        check("R10 readback held on raise", rbof(1), 0);
        cmd(1, 2'b10, 0); tick();
        check("R5 sender 0 mask", rbof(1), 4'b0001);
        cmd(1, 2'b11, 0); tick();
        check("R10 readback held on ack", rbof(1), 4'b0001);
        tick();
        check("R10 readback held idle", rbof(1), 4'b0001);

        for (int k = 0; k < 600; k++) begin
            for (int c = 0; c < N; c++)
                if ($urandom_range(1, 0) == 1)
                    cmd(c, 2'($urandom_range(3, 0)), $urandom_range(N-1, 0));
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule